// File: doc/BRIEF.md
# DDS Serial Configuration Sequencer

This block programs a serial direct-digital-synthesis waveform generator through a write-only, three-wire link made of an active-low frame select, a serial clock and a serial data line. A single start strobe captures a 28-bit frequency tuning word, a 12-bit phase value and a few mode inputs. The block then sends a fixed list of five 16-bit command words, most significant bit first. First comes a control word that holds the generator in reset and selects two-write frequency loading. Next are two writes to frequency register 0, the low 14 bits of the tuning word and then the high 14 bits. After that comes a write to phase register 0. Last is a control word that releases reset.

The serial clock idles high and the generator samples data on each falling edge. Data changes only on rising edges. The serial clock runs at the system clock divided by twice `half_div`. In stream mode all five words go out back to back under one frame-select-low window of 80 clocks. In separate mode each word has its own frame, and the frame select stays high for `gap_periods + 1` serial clock periods between frames. `busy` covers the whole transfer, and `done` pulses once when the last frame closes.

Top module: `dds_cfg_seq`

## Requirements
- R1: The serial clock is high whenever frame select is high. The data line changes only on rising serial clock edges, so it is stable at every falling edge.
- R2: Exactly five 16-bit words are sent per start, MSB first, in this order: 0x2100 (bit 13 = two-write frequency load, bit 8 = reset held), low frequency word, high frequency word, phase word, final control word.
- R3: The low frequency word is 0x4000 | tuning[13:0] and the high frequency word is 0x4000 | tuning[27:14] (prefix 01 in bits 15:14). For example, tuning 0x68D gives 0x468D then 0x4000.
- R4: The phase word is 0xC000 | phase[11:0] (prefix 11 in bits 15:14, bits 13:12 zero).
- R5: The final word is 0x2000 when `keep_dual` is 1 and 0x0000 when it is 0.
- R6: With `stream_mode` = 1, frame select stays low across all five words, giving one frame of 80 falling edges. Frame select only ever rises after a whole multiple of 16 falling edges.
- R7: With `stream_mode` = 0, each word is its own frame. Between frames, frame select is high for exactly (gap_periods + 1) × 2 × half_div system clocks.
- R8: The first falling serial clock edge of each frame comes exactly half_div system clocks after frame select falls. Frame select rises exactly 2 × half_div system clocks after the last falling edge of the frame.
- R9: `busy` rises the cycle after an accepted start and falls the cycle frame select rises after the last word. `done` is high for exactly that one cycle.
- R10: A start strobe while `busy` is high is ignored: the words sent, the frame count and the single `done` pulse are unchanged.
- R11: After reset, frame select and serial clock are high, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to send the sequence |
| freq_word | input | 28 | Frequency tuning word, captured at start |
| phase_word | input | 12 | Phase value, captured at start |
| keep_dual | input | 1 | 1: final word keeps two-write loading (0x2000); 0: final word 0x0000 |
| stream_mode | input | 1 | 1: one continuous frame; 0: one frame per word |
| half_div | input | DIV_W | System clocks per half serial clock period, must be at least 1 |
| gap_periods | input | GAP_W | Extra serial clock periods of frame-select-high between frames |
| frame_n | output | 1 | Active-low frame select |
| ser_clk | output | 1 | Serial clock, idle high |
| ser_dat | output | 1 | Serial data, MSB first |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at end of sequence |

## Verification
The assertions assume that `half_div` is at least 1 whenever start is accepted. They also assume that start is a clean synchronous strobe. Every other input is only sampled at acceptance, so later changes cannot disturb a transfer. The stimulus uses half_div values of 1, 2 and 3 only, and it pulses start for one cycle. The one extra start is placed in the middle of a busy transfer, and it comes with different field values so that any leak would show up in the captured words.

// File: rtl/dds_seq_pkg.sv
package dds_seq_pkg;
  localparam int WORD_W   = 16;
  localparam int TUNE_W   = 28;
  localparam int HALF_W   = TUNE_W / 2;
  localparam int PH_W     = 12;
  localparam int N_WORDS  = 5;
  localparam int IDX_W    = $clog2(N_WORDS);
  localparam int BIT_W    = $clog2(WORD_W);

  localparam logic [WORD_W-1:0] CTL_DUAL_RST = 16'h2100;
  localparam logic [WORD_W-1:0] CTL_DUAL_RUN = 16'h2000;
  localparam logic [WORD_W-1:0] CTL_RUN      = 16'h0000;
  localparam logic [1:0]        PFX_FREQ0    = 2'b01;
  localparam logic [1:0]        PFX_PHASE0   = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL, ST_GAP
  } seq_state_e;

  function automatic logic [WORD_W-1:0] cmd_word(
    input logic [IDX_W-1:0]  idx,
    input logic [TUNE_W-1:0] tune,
    input logic [PH_W-1:0]   ph,
    input logic              keep
  );
    logic [WORD_W-1:0] w;
    case (idx)
      IDX_W'(0): w = CTL_DUAL_RST;
      IDX_W'(1): w = {PFX_FREQ0, tune[HALF_W-1:0]};
      IDX_W'(2): w = {PFX_FREQ0, tune[TUNE_W-1:HALF_W]};
      IDX_W'(3): w = {PFX_PHASE0, 2'b00, ph};
      IDX_W'(4): w = keep ? CTL_DUAL_RUN : CTL_RUN;
      default:   w = CTL_RUN;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/dds_half_tick.sv
module dds_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign tick = run && (({1'b0, cnt_q} + (DIV_W+1)'(1)) >= {1'b0, half_div});

  always_comb begin
    cnt_en = 1'b1;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dds_word_sel.sv
module dds_word_sel
  import dds_seq_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [TUNE_W-1:0] tune,
  input  logic [PH_W-1:0]   ph,
  input  logic              keep,
  output logic [WORD_W-1:0] word
);
  assign word = cmd_word(idx, tune, ph, keep);
endmodule

// File: rtl/dds_link_fsm.sv
module dds_link_fsm
  import dds_seq_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int GAP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  input  logic [WORD_W-1:0] word,
  input  logic [TUNE_W-1:0] freq_word,
  input  logic [PH_W-1:0]   phase_word,
  input  logic              keep_dual,
  input  logic              stream_mode,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [GAP_W-1:0]  gap_periods,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [TUNE_W-1:0] tune_q,
  output logic [PH_W-1:0]   ph_q,
  output logic              keep_q,
  output logic [DIV_W-1:0]  half_q,
  output logic              frame_n,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              busy,
  output logic              done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  seq_state_e        st_q, st_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [GAP_W:0]    gcnt_q, gcnt_d;
  logic              fr_q, fr_d, sck_q, sck_d, busy_q, busy_d, done_d, done_q;
  logic              stream_q;
  logic [GAP_W-1:0]  gap_q;
  logic              accept, last_word;

  assign accept    = (st_q == ST_IDLE) && start;
  assign last_word = (idx_q == LAST_IDX);
  assign sel_idx   = (st_q == ST_IDLE) ? '0 : idx_q + IDX_W'(1);

  always_comb begin
    st_d   = st_q;   sh_d   = sh_q;   bit_d  = bit_q;  idx_d = idx_q;
    gcnt_d = gcnt_q; fr_d   = fr_q;   sck_d  = sck_q;  busy_d = busy_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_LEAD; fr_d = 1'b0; busy_d = 1'b1;
        sh_d = word; idx_d = '0; bit_d = '0;
      end
      ST_LEAD: if (tick) begin
        sck_d = 1'b0; st_d = ST_SHIFT;
      end
      ST_SHIFT: if (tick) begin
        if (sck_q) sck_d = 1'b0;
        else begin
          sck_d = 1'b1;
          if (bit_q == LAST_BIT) begin
            if (last_word || !stream_q) st_d = ST_TRAIL;
            else begin
              sh_d = word; bit_d = '0; idx_d = idx_q + IDX_W'(1);
            end
          end else begin
            sh_d  = {sh_q[WORD_W-2:0], 1'b0};
            bit_d = bit_q + BIT_W'(1);
          end
        end
      end
      ST_TRAIL: if (tick) begin
        fr_d = 1'b1;
        if (last_word) begin
          st_d = ST_IDLE; busy_d = 1'b0; done_d = 1'b1;
        end else begin
          st_d = ST_GAP; gcnt_d = '0;
        end
      end
      ST_GAP: if (tick) begin
        if (gcnt_q == {gap_q, 1'b1}) begin
          st_d = ST_LEAD; fr_d = 1'b0; sh_d = word;
          idx_d = idx_q + IDX_W'(1); bit_d = '0;
        end else gcnt_d = gcnt_q + (GAP_W+1)'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; sh_q <= '0; bit_q <= '0; idx_q <= '0; gcnt_q <= '0;
      fr_q <= 1'b1; sck_q <= 1'b1; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; sh_q <= sh_d; bit_q <= bit_d; idx_q <= idx_d; gcnt_q <= gcnt_d;
      fr_q <= fr_d; sck_q <= sck_d; busy_q <= busy_d; done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tune_q <= '0; ph_q <= '0; keep_q <= 1'b0; stream_q <= 1'b0;
      half_q <= '0; gap_q <= '0;
    end else if (accept) begin
      tune_q <= freq_word; ph_q <= phase_word; keep_q <= keep_dual;
      stream_q <= stream_mode; half_q <= half_div; gap_q <= gap_periods;
    end
  end

  assign frame_n = fr_q;
  assign ser_clk = sck_q;
  assign ser_dat = sh_q[WORD_W-1];
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

// File: rtl/dds_cfg_seq.sv
module dds_cfg_seq
  import dds_seq_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int GAP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TUNE_W-1:0] freq_word,
  input  logic [PH_W-1:0]   phase_word,
  input  logic              keep_dual,
  input  logic              stream_mode,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [GAP_W-1:0]  gap_periods,
  output logic              frame_n,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              busy,
  output logic              done
);
  logic              tick;
  logic [WORD_W-1:0] word;
  logic [IDX_W-1:0]  sel_idx;
  logic [TUNE_W-1:0] tune_q;
  logic [PH_W-1:0]   ph_q;
  logic              keep_q;
  logic [DIV_W-1:0]  half_q;

  dds_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_div(half_q), .tick(tick)
  );

  dds_word_sel u_sel (
    .idx(sel_idx), .tune(tune_q), .ph(ph_q), .keep(keep_q), .word(word)
  );

  dds_link_fsm #(.DIV_W(DIV_W), .GAP_W(GAP_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .word(word),
    .freq_word(freq_word), .phase_word(phase_word), .keep_dual(keep_dual),
    .stream_mode(stream_mode), .half_div(half_div), .gap_periods(gap_periods),
    .sel_idx(sel_idx), .tune_q(tune_q), .ph_q(ph_q), .keep_q(keep_q),
    .half_q(half_q), .frame_n(frame_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .busy(busy), .done(done)
  );
endmodule

// File: rtl/dds_cfg_seq_chk.sv
module dds_cfg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic frame_n,
  input logic ser_clk,
  input logic ser_dat,
  input logic busy,
  input logic done
);
  AST_CLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n |-> ser_clk);                                   // R1
  AST_DATA_STABLE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> $stable(ser_dat));                   // R1
  AST_RISE_AFTER_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_n) |-> ser_clk && $past(ser_clk));          // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                        // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy) && frame_n);              // R9
  AST_FRAME_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> busy);                                     // R9
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));                          // R10
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> frame_n && ser_clk);                          // R11
endmodule

bind dds_cfg_seq dds_cfg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .frame_n(frame_n),
  .ser_clk(ser_clk), .ser_dat(ser_dat), .busy(busy), .done(done)
);

// File: tb/sim_dds_cfg_seq.sv
module sim_dds_cfg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;
  localparam int GAP_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [27:0] freq_word = '0;
  logic [11:0] phase_word = '0;
  logic keep_dual = 1'b0, stream_mode = 1'b0;
  logic [DIV_W-1:0] half_div = 8'd1;
  logic [GAP_W-1:0] gap_periods = '0;
  logic frame_n, ser_clk, ser_dat, busy, done;

  dds_cfg_seq #(.DIV_W(DIV_W), .GAP_W(GAP_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .freq_word(freq_word),
    .phase_word(phase_word), .keep_dual(keep_dual), .stream_mode(stream_mode),
    .half_div(half_div), .gap_periods(gap_periods), .frame_n(frame_n),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int hd = 1, gp = 0;
  bit strm = 0, finished = 0;
  logic [15:0] expq[$];
  int frames = 0, dones = 0, nb = 0, err_cont = 0;
  int t_fall_fr = 0, t_last_fall = 0, t_rise = 0;
  bit first_fall = 0, rise_valid = 0;
  logic p_fr = 1'b1, p_sck = 1'b1;
  logic [15:0] shin = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int i, input logic [27:0] f,
                                           input logic [11:0] p, input bit k);
    case (i)
      0: return 16'h2100;
      1: return {2'b01, f[13:0]};
      2: return {2'b01, f[27:14]};
      3: return {4'b1100, p};
      default: return k ? 16'h2000 : 16'h0000;
    endcase
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: samples away from the active edge
  always @(negedge clk) if (rst_n) begin
    if (frame_n && !ser_clk) err_cont++;      // R1
    if (!frame_n && !busy)   err_cont++;      // R9
    if (p_fr && !frame_n) begin
      t_fall_fr = cyc; first_fall = 1;
      if (rise_valid && !strm)
        check(cyc - t_rise == (gp + 1) * 2 * hd, "R7 gap length", cyc - t_rise, (gp + 1) * 2 * hd);
    end
    if (p_sck && !ser_clk && !frame_n) begin
      if (first_fall) begin
        check(cyc - t_fall_fr == hd, "R8 lead time", cyc - t_fall_fr, hd);
        first_fall = 0;
      end
      shin = {shin[14:0], ser_dat};
      nb++;
      t_last_fall = cyc;
      if (nb % 16 == 0) begin
        if (expq.size() == 0) check(0, "R2 unexpected word", shin, 0);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          check(shin == e, "R2/R3/R4/R5 word", shin, e);
        end
      end
    end
    if (!p_fr && frame_n) begin
      check(nb % 16 == 0, "R6 whole words", nb, 16);
      check(cyc - t_last_fall == 2 * hd, "R8 trail time", cyc - t_last_fall, 2 * hd);
      frames++; nb = 0; t_rise = cyc; rise_valid = 1;
    end
    if (done) dones++;
    p_fr = frame_n; p_sck = ser_clk;
  end

  task automatic run_seq(input logic [27:0] f, input logic [11:0] p, input bit k,
                         input bit s, input int h, input int g, input bit poke);
    int d0, f0;
    @(posedge clk); #1;
    hd = h; gp = g; strm = s; rise_valid = 0; err_cont = 0;
    for (int i = 0; i < 5; i++) expq.push_back(exp_word(i, f, p, k));
    freq_word = f; phase_word = p; keep_dual = k; stream_mode = s;
    half_div = DIV_W'(h); gap_periods = GAP_W'(g);
    d0 = dones; f0 = frames;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    if (poke) begin
      repeat (40) @(posedge clk); #1;
      freq_word = 28'hFFFFFFF; phase_word = 12'h0F0; keep_dual = ~k; stream_mode = ~s;
      start = 1'b1;                                   // R10 start while busy
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (dones == d0) @(posedge clk);
    #1;
    check(busy == 1'b0, "R9 busy low at done", busy, 0);
    repeat (8) @(posedge clk); #1;
    check(dones == d0 + 1, "R9/R10 one done pulse", dones - d0, 1);
    check(expq.size() == 0, "R2 five words", expq.size(), 0);
    check(frames - f0 == (s ? 1 : 5), s ? "R6 one frame" : "R7 five frames", frames - f0, s ? 1 : 5);
    check(err_cont == 0, "R1/R9 line invariants", err_cont, 0);
    check(frame_n && ser_clk && !busy && !done, "R11 idle after run", {frame_n, ser_clk, busy, done}, 4'b1100);
    expq.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    check(frame_n && ser_clk && !busy && !done, "R11 reset state", {frame_n, ser_clk, busy, done}, 4'b1100);
    rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    check(frame_n && ser_clk && !busy && !done, "R11 after release", {frame_n, ser_clk, busy, done}, 4'b1100);
    run_seq(28'h000068D, 12'h000, 1'b1, 1'b0, 2, 1, 1'b0);  // R3 100 Hz example, R5 keep
    run_seq(28'hFFFFFFF, 12'hFFF, 1'b0, 1'b1, 1, 0, 1'b0);  // R6 stream, R4, R5 clear
    run_seq(28'h1234567, 12'h5A3, 1'b1, 1'b0, 3, 0, 1'b1);  // R10 ignored start, R7 gap 0
    run_seq(28'h000068D, 12'h800, 1'b0, 1'b1, 2, 7, 1'b0);  // R6 stream ignores gap
    run_seq(28'h2AAA555, 12'h001, 1'b1, 1'b0, 1, 3, 1'b0);  // R7 gap 3, R8 fast clock
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule